// File: doc/BRIEF.md
# Prioritised Interrupt Distributor

This block collects a parameterised set of interrupt lines, keeps the state of each one, and tells a single processor which line it should service next. Every line carries an enable flag, a pending flag, an active flag, an 8-bit priority and a trigger mode. Together the pending and active flags place each line in one of four states: idle, pending, in service (active), or in service with a new request queued (active and pending). Software reads and changes this state through a word-addressed register bus. Enable, pending and active are each reached through two banks: one bank sets bits and the other clears them.

The block compares every line that is both enabled and pending and presents the winner as an interrupt request together with its ID. When no line qualifies, or when the global enable is off, it presents ID 1023 with the request low. The processor acknowledges the presented line with a one-cycle strobe and later ends service by giving an end-of-interrupt strobe that names the ID. Line n carries ID n. IDs 0 to 15 are meant for software-raised sources, 16 to 31 for per-processor sources, and 32 and above for shared sources. The block treats all of them the same way.

Register map (word addresses on `reg_addr`): 0x000 control, 0x001 capability (read-only), 0x002 identity constant (read-only, 0x00010A5C). Each bit bank is one bit per line, line n at bit n%32 of word n/32: enable-set at 0x020, enable-clear at 0x030, pending-set at 0x040, pending-clear at 0x050, active-set at 0x060, active-clear at 0x070, trigger mode at 0x080. Priorities start at 0x100, four per word, with line n in byte n%4 of word 0x100+n/4.

Top module: `irq_distributor`

## Requirements
- R1: Writing a 1 to a bit of a set bank (0x020 enable, 0x040 pending, 0x060 active) sets that attribute of the line. Writing a 1 to a bit of the matching clear bank (0x030, 0x050, 0x070) clears it. Writing 0 bits changes nothing.
- R2: A read of either the set word or the clear word of an attribute returns the present value of that attribute, one bit per line.
- R3: Each line's 8-bit priority can be written and read back in full at word 0x100+n/4, byte n%4.
- R4: The trigger bank at 0x080 reads and writes 1 for edge mode and 0 for level mode. An edge line becomes pending on a rising edge of its input. A level line becomes pending while its input is high and the line is not active. A hardware pending event wins over a pending-clear write in the same cycle.
- R5: With the global enable set, `irq_req_o` is high and `irq_id_o` is the qualifying line (enabled and pending) that has the numerically lowest priority value. Ties go to the lower ID.
- R6: `irq_req_o` is low and `irq_id_o` is 1023 when no line qualifies or when control bit 0 (global enable) is 0.
- R7: An acknowledge strobe while `irq_req_o` is high clears the pending flag of the presented line and sets its active flag. This includes an edge line that is active and pending. An acknowledge while the request is low has no effect.
- R8: An end-of-interrupt strobe clears the active flag of line `done_id`, and IDs at or above the line count are ignored. A level line whose input is still high becomes pending on the same clock edge.
- R9: A write to control stores the word with bit 6 forced to 0. The capability word is read-only and holds (line count/32)-1 in bits [4:0], processor count minus one (0) in bits [7:5], and 9 in bits [23:19].
- R10: After reset all flags are 0, all priorities are 0, all lines are in level mode, and control is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_IRQ | Interrupt source inputs, synchronous to clk |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write when high together with reg_sel |
| reg_addr | input | 10 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, follows reg_addr combinationally |
| intr_ack | input | 1 | Acknowledge the presented interrupt |
| intr_done | input | 1 | End-of-interrupt strobe |
| done_id | input | 10 | ID whose service ends |
| irq_req_o | output | 1 | Interrupt request to the processor |
| irq_id_o | output | 10 | Presented ID, 1023 when none |

## Verification
The per-line properties assume that a register write and an acknowledge or end-of-interrupt strobe do not act on the same line in the same cycle. Several of them are written with exception terms for this case so that they still hold when it happens. The acknowledge properties take for granted that `intr_ack` is only meaningful while a request is presented. The bench keeps to these assumptions: each operation occupies its own cycle, and random end-of-interrupt IDs are drawn from a range that includes IDs past the last line so that the ignored case is also exercised.

// File: rtl/irqd_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the interrupt distributor.
// Assumes a 10-bit interrupt ID space with 1023 reserved as "none".
package irqd_pkg;
    localparam int ID_W      = 10;
    localparam int PRIO_W    = 8;
    localparam int CPU_COUNT = 1;

    typedef logic [PRIO_W-1:0] prio_t;

    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    // word addresses of the register map
    localparam int A_CTRL   = 'h000;
    localparam int A_CAPS   = 'h001;
    localparam int A_IDENT  = 'h002;
    localparam int A_EN_SET = 'h020;
    localparam int A_EN_CLR = 'h030;
    localparam int A_PD_SET = 'h040;
    localparam int A_PD_CLR = 'h050;
    localparam int A_AC_SET = 'h060;
    localparam int A_AC_CLR = 'h070;
    localparam int A_TRIG   = 'h080;
    localparam int A_PRIO   = 'h100;

    localparam logic [31:0] IDENT_VALUE = 32'h0001_0A5C;
    localparam int CTRL_EN_BIT      = 0;
    localparam int CTRL_FORCED0_BIT = 6;
endpackage

// File: rtl/irqd_regif.sv
`timescale 1ns/1ps
// Register interface: decodes bus writes into per-line set/clear masks,
// holds the control word and muxes read data.
// Assumes NUM_IRQ is a multiple of 32; read data is combinational from reg_addr.
module irqd_regif
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_sel,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_IRQ-1:0]   en_q,
    input  logic [NUM_IRQ-1:0]   pd_q,
    input  logic [NUM_IRQ-1:0]   ac_q,
    input  logic [NUM_IRQ-1:0]   edge_q,
    input  prio_t [NUM_IRQ-1:0]  prio_q,
    output logic                 ctrl_en,
    output logic [NUM_IRQ-1:0]   en_set,
    output logic [NUM_IRQ-1:0]   en_clr,
    output logic [NUM_IRQ-1:0]   pd_set,
    output logic [NUM_IRQ-1:0]   pd_clr,
    output logic [NUM_IRQ-1:0]   ac_set,
    output logic [NUM_IRQ-1:0]   ac_clr,
    output logic [NUM_IRQ-1:0]   trig_wr,
    output logic [NUM_IRQ-1:0]   trig_val,
    output logic [NUM_IRQ-1:0]   prio_wr,
    output prio_t [NUM_IRQ-1:0]  prio_val
);
    localparam int WORDS      = NUM_IRQ / 32;
    localparam int PRIO_WORDS = NUM_IRQ / 4;
    localparam logic [31:0] CAPS_VALUE =
        {8'd0, 5'(ID_W - 1), 11'd0, 3'(CPU_COUNT - 1), 5'(WORDS - 1)};

    logic        wr_en;
    logic [31:0] ctrl_q;

    assign wr_en   = reg_sel && reg_wr;
    assign ctrl_en = ctrl_q[CTRL_EN_BIT];

    // Control word storage; one bit is never allowed to stick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && reg_addr == ADDR_W'(A_CTRL)) begin
            ctrl_q <= reg_wdata & ~(32'd1 << CTRL_FORCED0_BIT);
        end
    end

    // Turn a bus write into per-line strobes for every bank.
    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            en_set[i]   = wr_en && reg_addr == ADDR_W'(A_EN_SET + i / 32) && reg_wdata[i % 32];
            en_clr[i]   = wr_en && reg_addr == ADDR_W'(A_EN_CLR + i / 32) && reg_wdata[i % 32];
            pd_set[i]   = wr_en && reg_addr == ADDR_W'(A_PD_SET + i / 32) && reg_wdata[i % 32];
            pd_clr[i]   = wr_en && reg_addr == ADDR_W'(A_PD_CLR + i / 32) && reg_wdata[i % 32];
            ac_set[i]   = wr_en && reg_addr == ADDR_W'(A_AC_SET + i / 32) && reg_wdata[i % 32];
            ac_clr[i]   = wr_en && reg_addr == ADDR_W'(A_AC_CLR + i / 32) && reg_wdata[i % 32];
            trig_wr[i]  = wr_en && reg_addr == ADDR_W'(A_TRIG + i / 32);
            trig_val[i] = reg_wdata[i % 32];
            prio_wr[i]  = wr_en && reg_addr == ADDR_W'(A_PRIO + i / 4);
            prio_val[i] = reg_wdata[8 * (i % 4) +: 8];
        end
    end

    // Read mux: both banks of an attribute show its current value.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL))  reg_rdata = ctrl_q;
        if (reg_addr == ADDR_W'(A_CAPS))  reg_rdata = CAPS_VALUE;
        if (reg_addr == ADDR_W'(A_IDENT)) reg_rdata = IDENT_VALUE;
        for (int w = 0; w < WORDS; w++) begin
            if (reg_addr == ADDR_W'(A_EN_SET + w) || reg_addr == ADDR_W'(A_EN_CLR + w))
                reg_rdata = en_q[32 * w +: 32];
            if (reg_addr == ADDR_W'(A_PD_SET + w) || reg_addr == ADDR_W'(A_PD_CLR + w))
                reg_rdata = pd_q[32 * w +: 32];
            if (reg_addr == ADDR_W'(A_AC_SET + w) || reg_addr == ADDR_W'(A_AC_CLR + w))
                reg_rdata = ac_q[32 * w +: 32];
            if (reg_addr == ADDR_W'(A_TRIG + w))
                reg_rdata = edge_q[32 * w +: 32];
        end
        for (int w = 0; w < PRIO_WORDS; w++) begin
            if (reg_addr == ADDR_W'(A_PRIO + w))
                reg_rdata = prio_q[4 * w +: 4];
        end
    end

    assert_ctrl_bit_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && reg_addr == ADDR_W'(A_CTRL) |=> !ctrl_q[CTRL_FORCED0_BIT]);
endmodule

// File: rtl/irqd_lines.sv
`timescale 1ns/1ps
// Per-line state: enable, pending, active, trigger mode and priority.
// Assumes irq_in is already synchronous to clk. Hardware pending events
// win over a software pending-clear in the same cycle.
module irqd_lines
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQ-1:0]   irq_in,
    input  logic [NUM_IRQ-1:0]   en_set,
    input  logic [NUM_IRQ-1:0]   en_clr,
    input  logic [NUM_IRQ-1:0]   pd_set,
    input  logic [NUM_IRQ-1:0]   pd_clr,
    input  logic [NUM_IRQ-1:0]   ac_set,
    input  logic [NUM_IRQ-1:0]   ac_clr,
    input  logic [NUM_IRQ-1:0]   trig_wr,
    input  logic [NUM_IRQ-1:0]   trig_val,
    input  logic [NUM_IRQ-1:0]   prio_wr,
    input  prio_t [NUM_IRQ-1:0]  prio_val,
    input  logic [NUM_IRQ-1:0]   ack_hit,
    input  logic [NUM_IRQ-1:0]   eoi_hit,
    output logic [NUM_IRQ-1:0]   en_q,
    output logic [NUM_IRQ-1:0]   pd_q,
    output logic [NUM_IRQ-1:0]   ac_q,
    output logic [NUM_IRQ-1:0]   edge_q,
    output prio_t [NUM_IRQ-1:0]  prio_q
);
    logic [NUM_IRQ-1:0] prev_in;
    logic [NUM_IRQ-1:0] act_next;
    logic [NUM_IRQ-1:0] hw_pend;

    // Next active state and hardware-raised pending events.
    always_comb begin
        act_next = (ac_q | ac_set | ack_hit) & ~ac_clr & ~eoi_hit;
        hw_pend  = (edge_q & irq_in & ~prev_in) | (~edge_q & irq_in & ~act_next);
    end

    // Flag registers and input history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            pd_q    <= '0;
            ac_q    <= '0;
            edge_q  <= '0;
            prev_in <= '0;
        end else begin
            en_q    <= (en_q | en_set) & ~en_clr;
            pd_q    <= (pd_q & ~ack_hit & ~pd_clr) | pd_set | hw_pend;
            ac_q    <= act_next;
            edge_q  <= (edge_q & ~trig_wr) | (trig_val & trig_wr);
            prev_in <= irq_in;
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        // Priority byte of one line.
        always_ff @(posedge clk) begin
            if (!rst_n)          prio_q[g] <= '0;
            else if (prio_wr[g]) prio_q[g] <= prio_val[g];
        end

        assert_enable_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
            en_set[g] && !en_clr[g] |=> en_q[g]);
        assert_ack_activates_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ack_hit[g] && !ac_clr[g] && !eoi_hit[g] |=> ac_q[g]);
        assert_ack_unpends_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ack_hit[g] && !pd_set[g] && !(edge_q[g] && irq_in[g] && !prev_in[g]) |=> !pd_q[g]);
        assert_level_repend_R8: assert property (@(posedge clk) disable iff (!rst_n)
            eoi_hit[g] && !edge_q[g] && irq_in[g] && !ack_hit[g] && !ac_set[g] |=> pd_q[g]);
    end
endmodule

// File: rtl/irqd_arbiter.sv
`timescale 1ns/1ps
// Combinational comparison tree picking the candidate with the lowest
// priority value; the left (lower ID) side wins ties. Pads to a power of two.
module irqd_arbiter
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0]   cand,
    input  prio_t [NUM_IRQ-1:0]  prio_q,
    output logic                 win_valid,
    output logic [ID_W-1:0]      win_id
);
    localparam int LEVELS = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] nv;
    prio_t            np  [NODES];
    logic [ID_W-1:0]  nid [NODES];

    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        if (j < NUM_IRQ) begin : g_real
            assign nv[LEAVES-1+j]  = cand[j];
            assign np[LEAVES-1+j]  = prio_q[j];
            assign nid[LEAVES-1+j] = ID_W'(j);
        end else begin : g_pad
            assign nv[LEAVES-1+j]  = 1'b0;
            assign np[LEAVES-1+j]  = '1;
            assign nid[LEAVES-1+j] = SPURIOUS_ID;
        end
    end

    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        logic take_right;
        assign take_right = nv[2*k+2] && (!nv[2*k+1] || np[2*k+2] < np[2*k+1]);
        assign nv[k]  = nv[2*k+1] | nv[2*k+2];
        assign np[k]  = take_right ? np[2*k+2]  : np[2*k+1];
        assign nid[k] = take_right ? nid[2*k+2] : nid[2*k+1];
    end

    assign win_valid = nv[0];
    assign win_id    = nid[0];
endmodule

// File: rtl/irq_distributor.sv
`timescale 1ns/1ps
// Top of the interrupt distributor: register interface, line state and
// arbitration, plus the acknowledge / end-of-interrupt decode.
// Assumes a single target processor and NUM_IRQ a multiple of 32 (32..256).
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               intr_ack,
    input  logic               intr_done,
    input  logic [ID_W-1:0]    done_id,
    output logic               irq_req_o,
    output logic [ID_W-1:0]    irq_id_o
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic [NUM_IRQ-1:0] en_q, pd_q, ac_q, edge_q;
    prio_t [NUM_IRQ-1:0] prio_q, prio_val;
    logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr, ac_set, ac_clr;
    logic [NUM_IRQ-1:0] trig_wr, trig_val, prio_wr;
    logic [NUM_IRQ-1:0] ack_hit, eoi_hit;
    logic               ctrl_en, win_valid;
    logic [ID_W-1:0]    win_id;
    logic [IDX_W-1:0]   sel_idx;

    irqd_regif #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .en_q(en_q), .pd_q(pd_q), .ac_q(ac_q), .edge_q(edge_q), .prio_q(prio_q),
        .ctrl_en(ctrl_en),
        .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
        .ac_set(ac_set), .ac_clr(ac_clr), .trig_wr(trig_wr), .trig_val(trig_val),
        .prio_wr(prio_wr), .prio_val(prio_val)
    );

    irqd_lines #(.NUM_IRQ(NUM_IRQ)) u_lines (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
        .ac_set(ac_set), .ac_clr(ac_clr), .trig_wr(trig_wr), .trig_val(trig_val),
        .prio_wr(prio_wr), .prio_val(prio_val),
        .ack_hit(ack_hit), .eoi_hit(eoi_hit),
        .en_q(en_q), .pd_q(pd_q), .ac_q(ac_q), .edge_q(edge_q), .prio_q(prio_q)
    );

    irqd_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
        .cand(en_q & pd_q), .prio_q(prio_q),
        .win_valid(win_valid), .win_id(win_id)
    );

    // Request output, gated by the global enable.
    always_comb begin
        irq_req_o = ctrl_en && win_valid;
        irq_id_o  = irq_req_o ? win_id : SPURIOUS_ID;
        sel_idx   = win_id[IDX_W-1:0];
    end

    // Map acknowledge and end-of-interrupt strobes onto single lines.
    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            ack_hit[i] = intr_ack && irq_req_o && win_id == ID_W'(i);
            eoi_hit[i] = intr_done && done_id == ID_W'(i);
        end
    end

    assert_winner_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> en_q[sel_idx] && pd_q[sel_idx]);
    assert_off_reports_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> irq_id_o == SPURIOUS_ID);
    assert_single_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hit));
endmodule

// File: tb/tb_irq_distributor.sv
`timescale 1ns/1ps
module tb_irq_distributor;
    localparam int N = 32;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [N-1:0] irq_in = '0;
    logic        reg_sel = 0, reg_wr = 0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        intr_ack = 0, intr_done = 0;
    logic [9:0]  done_id = '0;
    logic        irq_req_o;
    logic [9:0]  irq_id_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // reference model
    bit [N-1:0] m_en, m_pd, m_ac, m_edge, m_prev;
    bit [7:0]   m_prio [N];
    bit [31:0]  m_ctrl;

    irq_distributor dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .intr_ack(intr_ack), .intr_done(intr_done), .done_id(done_id),
        .irq_req_o(irq_req_o), .irq_id_o(irq_id_o)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_id();
        int best = -1;
        if (!m_ctrl[0]) return 1023;
        for (int i = 0; i < N; i++)
            if (m_en[i] && m_pd[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
        return (best < 0) ? 1023 : best;
    endfunction

    function automatic logic [31:0] model_read(logic [9:0] a);
        case (a)
            10'h000: return m_ctrl;
            10'h001: return 32'h0048_0000;
            10'h002: return 32'h0001_0A5C;
            10'h020, 10'h030: return m_en;
            10'h040, 10'h050: return m_pd;
            10'h060, 10'h070: return m_ac;
            10'h080: return m_edge;
            default: begin
                if (a >= 10'h100 && a < 10'h108) begin
                    int w = int'(a) - 'h100;
                    return {m_prio[4*w+3], m_prio[4*w+2], m_prio[4*w+1], m_prio[4*w]};
                end
                return 32'h0;
            end
        endcase
    endfunction

    task automatic check_out();
        int e = exp_id();
        chk(e == 1023 ? "R6" : "R5", {31'd0, irq_req_o}, {31'd0, e != 1023}, "irq_req_o");
        chk(e == 1023 ? "R6" : "R5", {22'd0, irq_id_o}, 32'(e), "irq_id_o");
    endtask

    // One clock cycle with the currently driven inputs; the model advances alongside.
    task automatic tick();
        bit [N-1:0] es = 0, ec = 0, ps = 0, pc = 0, as_ = 0, acl = 0, ak = 0, eo = 0;
        bit [N-1:0] an, hw, n_edge;
        bit [31:0]  n_ctrl;
        bit [7:0]   n_prio [N];
        int w;
        n_edge = m_edge; n_ctrl = m_ctrl;
        for (int i = 0; i < N; i++) n_prio[i] = m_prio[i];
        if (reg_sel && reg_wr) begin
            case (reg_addr)
                10'h000: n_ctrl = reg_wdata & ~32'h40;
                10'h020: es = reg_wdata;
                10'h030: ec = reg_wdata;
                10'h040: ps = reg_wdata;
                10'h050: pc = reg_wdata;
                10'h060: as_ = reg_wdata;
                10'h070: acl = reg_wdata;
                10'h080: n_edge = reg_wdata;
                default: if (reg_addr >= 10'h100 && reg_addr < 10'h108) begin
                    w = int'(reg_addr) - 'h100;
                    for (int b = 0; b < 4; b++) n_prio[4*w+b] = reg_wdata[8*b +: 8];
                end
            endcase
        end
        w = exp_id();
        if (intr_ack && w != 1023) ak[w] = 1;
        if (intr_done && done_id < N) eo[done_id] = 1;
        an = (m_ac | as_ | ak) & ~acl & ~eo;
        hw = (m_edge & irq_in & ~m_prev) | (~m_edge & irq_in & ~an);
        @(posedge clk);
        m_pd = (m_pd & ~ak & ~pc) | ps | hw;
        m_en = (m_en | es) & ~ec;
        m_ac = an;
        m_prev = irq_in;
        m_edge = n_edge;
        m_ctrl = n_ctrl;
        for (int i = 0; i < N; i++) m_prio[i] = n_prio[i];
        @(negedge clk);
        reg_sel = 0; reg_wr = 0; intr_ack = 0; intr_done = 0;
        check_out();
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic rd(logic [9:0] a, string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, model_read(a), $sformatf("read %h", a));
    endtask

    task automatic rd_lit(logic [9:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp, $sformatf("read %h", a));
    endtask

    task automatic ack();
        intr_ack = 1;
        tick();
    endtask

    task automatic eoi(int id);
        intr_done = 1; done_id = 10'(id);
        tick();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [9:0] addrs [11];
        addrs = '{10'h000, 10'h001, 10'h002, 10'h020, 10'h030, 10'h040,
                  10'h050, 10'h060, 10'h070, 10'h080, 10'h100};
        m_en = 0; m_pd = 0; m_ac = 0; m_edge = 0; m_prev = 0; m_ctrl = 0;
        for (int i = 0; i < N; i++) m_prio[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R10 reset state
        rd_lit(10'h000, 32'h0, "R10");
        rd_lit(10'h020, 32'h0, "R10");
        rd_lit(10'h040, 32'h0, "R10");
        rd_lit(10'h060, 32'h0, "R10");
        rd_lit(10'h080, 32'h0, "R10");
        rd_lit(10'h103, 32'h0, "R10");
        chk("R6", {22'd0, irq_id_o}, 32'd1023, "id after reset");
        chk("R6", {31'd0, irq_req_o}, 32'd0, "req after reset");

        // R9 control forcing and read-only capability word
        wr(10'h000, 32'hFFFF_FFFF);
        rd_lit(10'h000, 32'hFFFF_FFBF, "R9");
        wr(10'h001, 32'h0000_FFFF);
        rd_lit(10'h001, 32'h0048_0000, "R9");
        wr(10'h000, 32'h1);

        // R3 priority packing
        wr(10'h100, 32'h4030_2010);
        rd_lit(10'h100, 32'h4030_2010, "R3");
        wr(10'h100, 32'h3000_0000);
        wr(10'h101, 32'h0000_2000);
        wr(10'h102, 32'h0000_2000);

        // R5 tie break between lines 5 and 9, line 3 worse
        wr(10'h020, 32'h228);
        wr(10'h040, 32'h228);
        chk("R5", {22'd0, irq_id_o}, 32'd5, "tie picks lower id");
        // R7 acknowledge
        ack();
        rd_lit(10'h060, 32'h20, "R7");
        rd_lit(10'h040, 32'h208, "R7");
        chk("R5", {22'd0, irq_id_o}, 32'd9, "next winner");
        // R8 end of interrupt
        eoi(5);
        rd_lit(10'h070, 32'h0, "R8");
        eoi(900);
        rd_lit(10'h040, 32'h208, "R8");
        // R6 global disable
        wr(10'h000, 32'h0);
        chk("R6", {22'd0, irq_id_o}, 32'd1023, "disabled id");
        chk("R6", {31'd0, irq_req_o}, 32'd0, "disabled req");
        ack();
        rd_lit(10'h060, 32'h0, "R7");
        wr(10'h000, 32'h1);
        // R1 zero writes change nothing, clear works
        wr(10'h020, 32'h0); wr(10'h030, 32'h0); wr(10'h050, 32'h0); wr(10'h070, 32'h0);
        rd_lit(10'h030, 32'h228, "R1");
        rd_lit(10'h050, 32'h208, "R2");
        wr(10'h050, 32'h228);
        rd_lit(10'h040, 32'h0, "R1");
        chk("R6", {22'd0, irq_id_o}, 32'd1023, "nothing pending");

        // R4 / R7 / R8 level line 7
        wr(10'h020, 32'h80);
        irq_in[7] = 1; tick();
        rd_lit(10'h040, 32'h80, "R4");
        chk("R5", {22'd0, irq_id_o}, 32'd7, "level winner");
        ack();
        rd_lit(10'h040, 32'h0, "R7");
        tick(); tick();
        rd_lit(10'h040, 32'h0, "R4");
        eoi(7);
        rd_lit(10'h040, 32'h80, "R8");
        rd_lit(10'h060, 32'h0, "R8");
        irq_in[7] = 0;
        wr(10'h050, 32'h80);

        // R4 / R7 edge line 12
        wr(10'h080, 32'h1000);
        rd_lit(10'h080, 32'h1000, "R4");
        wr(10'h020, 32'h1000);
        irq_in[12] = 1; tick();
        rd_lit(10'h040, 32'h1000, "R4");
        wr(10'h050, 32'h1000);
        tick();
        rd_lit(10'h040, 32'h0, "R4");
        irq_in[12] = 0; tick();
        irq_in[12] = 1; tick();
        ack();
        irq_in[12] = 0; tick();
        irq_in[12] = 1; tick();
        rd_lit(10'h040, 32'h1000, "R7");
        rd_lit(10'h060, 32'h1000, "R7");
        ack();
        rd_lit(10'h040, 32'h0, "R7");
        rd_lit(10'h060, 32'h1000, "R7");
        eoi(12);
        rd_lit(10'h060, 32'h0, "R8");
        irq_in[12] = 0; tick();

        // constrained random phase
        void'($urandom(32'h5EED_1234));
        for (int it = 0; it < 4000; it++) begin
            int r = $urandom % 10;
            if (r < 3) begin
                logic [9:0] a = addrs[$urandom % 11];
                logic [31:0] d = $urandom & $urandom & $urandom;
                if (a == 10'h100) a = 10'h100 + 10'($urandom % 8);
                if (a == 10'h100 || a > 10'h100) d = $urandom;
                if (a == 10'h000) d = ($urandom % 8 == 0) ? $urandom & ~32'h1 : $urandom | 32'h1;
                wr(a, d);
            end else if (r == 3) begin
                irq_in = irq_in ^ (N'(1) << ($urandom % N));
                tick();
            end else if (r == 4) begin
                ack();
            end else if (r == 5) begin
                eoi($urandom % 40);
            end else if (r == 6) begin
                logic [9:0] a = addrs[$urandom % 11];
                if (a == 10'h100) a = 10'h100 + 10'($urandom % 8);
                rd(a, "R2");
            end else begin
                tick();
            end
        end
        finish_run();
    end
endmodule